// File: doc/BRIEF.md
# Fixed-Frame Instruction Control Unit

This block produces the per-cycle control strobes for a small 4-bit datapath. A free-running step counter divides the clock by seven, and a combinational decode table turns the 4-bit function code, together with the current step, into strobes for the datapath. The strobes are a bus-source select, a bus-destination select, ALU mode and operation bits, a carry-in, a rotate direction and a rotate enable. Every instruction therefore occupies exactly seven clock periods, and the next instruction starts on the step after the last one.

Instructions that take one operand reuse the same seven-step frame. They spend one more step with the output register on the bus, so the decode table never needs a shorter frame. Function codes with no instruction assigned to them leave every strobe inactive for the whole frame. The datapath registers, the ALU and instruction fetch lie outside this block.

Top module: `ctl_unit`

## Requirements
- R1: The step counter advances by one on each clock edge from 0 to 6 and then wraps to 0, so each instruction frame lasts exactly seven clock periods.
- R2: A synchronous reset sets the step to 0 and enables the decode table. While reset is asserted, every strobe is 0. In the cycle after reset is released, the step-0 strobes of the current function code are driven.
- R3: The bus-source select `oeSel` uses 0 for none, 1 for the output register, 2 for the input buffer and 3 for the ALU. The destination select `loadSel` uses 0 for none, 1 for register A, 2 for register B and 3 for the output buffer.
- R4: A two-operand instruction (AND, OR, XOR, ADD, SUB) drives the following {oeSel, loadSel} pairs: step 0 {1,0}, step 1 {2,1}, step 2 {2,2}, step 3 {3,0}, step 4 {3,3}.
- R5: A one-operand instruction (NOT, RRC, RLC) drives the following pairs: step 0 {1,0}, step 1 {1,0}, step 2 {2,1}, step 3 {3,0}, step 4 {3,3}. The output-register step is repeated.
- R6: `loadSel` = 3 (load output buffer) occurs only in step 4. Steps 5 and 6 drive every strobe to 0.
- R7: Function codes are 0000 NOT, 0001 AND, 0010 OR, 0011 XOR, 0100 ADD, 0101 SUB, 0110 RRC and 0111 RLC. In steps 3 and 4, `aluMode` is 1 for the logic codes (0000–0011) and 0 for the others, and `aluFunc` equals the low two bits of the code. In all other steps, `aluMode` and `aluFunc` are 0.
- R8: `carryIn` is 1 only in steps 3 and 4 of SUB.
- R9: `rotEn` is 1 only in steps 3 and 4 of RRC and RLC. `rotRight` is 1 only in those steps of RRC.
- R10: Any function code with bit 3 set leaves every strobe at 0 for all seven steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| funcCode | input | 4 | Function code of the current instruction |
| oeSel | output | 3 | Bus source select |
| loadSel | output | 3 | Bus destination select |
| aluMode | output | 1 | 1 = logic group, 0 = arithmetic/rotate group |
| aluFunc | output | 2 | Operation within the group |
| carryIn | output | 1 | ALU carry-in |
| rotRight | output | 1 | Rotate direction, 1 = right |
| rotEn | output | 1 | Rotate enable |

## Verification
The bench builds the block with its default values: a frame length of seven and a 4-bit function code. At these values, all sixteen codes crossed with all seven steps form a space small enough to cover exhaustively. Each defined instruction is run for a full frame, including two frames in a row that exercise the wrap. Two undefined codes are also run for full frames. A reset issued in the middle of a frame checks that the strobes go quiet and that the sequence restarts at step 0.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int FRAME_LEN = 7;
  localparam int STEP_W    = $clog2(FRAME_LEN);
  localparam int FC_W      = 4;

  localparam logic [2:0] SRC_NONE   = 3'd0;
  localparam logic [2:0] SRC_OUTREG = 3'd1;
  localparam logic [2:0] SRC_INBUF  = 3'd2;
  localparam logic [2:0] SRC_ALU    = 3'd3;

  localparam logic [2:0] DST_NONE   = 3'd0;
  localparam logic [2:0] DST_A      = 3'd1;
  localparam logic [2:0] DST_B      = 3'd2;
  localparam logic [2:0] DST_OUTBUF = 3'd3;

  typedef struct packed {
    logic [2:0] oeSel;
    logic [2:0] loadSel;
    logic       aluMode;
    logic [1:0] aluFunc;
    logic       carryIn;
    logic       rotRight;
    logic       rotEn;
  } strobe_t;
endpackage

// File: rtl/ctl_step_seq.sv
module ctl_step_seq #(
  parameter int FRAME_LEN = ctl_pkg::FRAME_LEN,
  localparam int STEP_W   = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STEP_W-1:0] stepNow,
  output logic              tableSel
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FRAME_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      stepNow  <= '0;
      tableSel <= 1'b1;
    end else begin
      stepNow <= (stepNow == LAST_STEP) ? '0 : stepNow + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_pkg::*;
#(
  parameter int STEP_W = ctl_pkg::STEP_W
) (
  input  logic [STEP_W-1:0] stepNow,
  input  logic [3:0]        funcCode,
  input  logic              enable,
  output strobe_t           strobes
);
  logic    codeValid;
  logic    singleOp;
  logic    aluStep;
  strobe_t raw;

  assign codeValid = ~funcCode[3];
  assign singleOp  = funcCode[2] ? funcCode[1] : (funcCode[1:0] == 2'b00);

  always_comb begin
    raw     = '0;
    aluStep = 1'b0;
    case (stepNow)
      STEP_W'(0): raw.oeSel = SRC_OUTREG;
      STEP_W'(1): begin
        if (singleOp) raw.oeSel = SRC_OUTREG;
        else begin
          raw.oeSel   = SRC_INBUF;
          raw.loadSel = DST_A;
        end
      end
      STEP_W'(2): begin
        raw.oeSel   = SRC_INBUF;
        raw.loadSel = singleOp ? DST_A : DST_B;
      end
      STEP_W'(3): begin
        raw.oeSel = SRC_ALU;
        aluStep   = 1'b1;
      end
      STEP_W'(4): begin
        raw.oeSel   = SRC_ALU;
        raw.loadSel = DST_OUTBUF;
        aluStep     = 1'b1;
      end
      default: ;
    endcase
    if (aluStep) begin
      raw.aluMode  = ~funcCode[2];
      raw.aluFunc  = funcCode[1:0];
      raw.carryIn  = funcCode[2] & ~funcCode[1] & funcCode[0];
      raw.rotEn    = funcCode[2] & funcCode[1];
      raw.rotRight = funcCode[2] & funcCode[1] & ~funcCode[0];
    end
  end

  assign strobes = (enable && codeValid) ? raw : '0;
endmodule

// File: rtl/ctl_unit.sv
module ctl_unit
  import ctl_pkg::*;
#(
  parameter int FRAME_LEN = ctl_pkg::FRAME_LEN,
  localparam int STEP_W   = $clog2(FRAME_LEN)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] funcCode,
  output logic [2:0] oeSel,
  output logic [2:0] loadSel,
  output logic       aluMode,
  output logic [1:0] aluFunc,
  output logic       carryIn,
  output logic       rotRight,
  output logic       rotEn
);
  logic [STEP_W-1:0] stepNow;
  logic              tableSel;
  strobe_t           strobes;

  ctl_step_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .stepNow  (stepNow),
    .tableSel (tableSel)
  );

  ctl_decode #(.STEP_W(STEP_W)) u_dec (
    .stepNow  (stepNow),
    .funcCode (funcCode),
    .enable   (tableSel & ~rst),
    .strobes  (strobes)
  );

  assign oeSel    = strobes.oeSel;
  assign loadSel  = strobes.loadSel;
  assign aluMode  = strobes.aluMode;
  assign aluFunc  = strobes.aluFunc;
  assign carryIn  = strobes.carryIn;
  assign rotRight = strobes.rotRight;
  assign rotEn    = strobes.rotEn;
endmodule

// File: rtl/ctl_unit_chk.sv
module ctl_unit_chk #(
  parameter int FRAME_LEN = 7,
  localparam int STEP_W   = $clog2(FRAME_LEN)
) (
  input logic              clk,
  input logic              rst,
  input logic [STEP_W-1:0] stepNow,
  input logic [3:0]        funcCode,
  input logic [2:0]        oeSel,
  input logic [2:0]        loadSel,
  input logic              carryIn,
  input logic              rotRight,
  input logic              rotEn
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FRAME_LEN - 1);

  // R1
  a_r1_step_range: assert property (@(posedge clk) disable iff (rst)
    stepNow <= LAST_STEP);
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    stepNow == LAST_STEP |=> stepNow == '0);
  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    stepNow != LAST_STEP |=> stepNow == $past(stepNow) + 1'b1);
  // R2
  a_r2_reset_step: assert property (@(posedge clk)
    rst |=> stepNow == '0);
  a_r2_reset_quiet: assert property (@(posedge clk)
    rst |-> (oeSel == 3'd0 && loadSel == 3'd0 && !rotEn && !carryIn));
  // R6
  a_r6_outbuf_last: assert property (@(posedge clk) disable iff (rst)
    loadSel == 3'd3 |-> stepNow == STEP_W'(4));
  // R8
  a_r8_cin_sub: assert property (@(posedge clk) disable iff (rst)
    carryIn |-> funcCode == 4'b0101);
  // R9
  a_r9_rot_alu: assert property (@(posedge clk) disable iff (rst)
    rotEn |-> (oeSel == 3'd3 && funcCode[3:1] == 3'b011));
  a_r9_dir_rrc: assert property (@(posedge clk) disable iff (rst)
    rotRight |-> (rotEn && funcCode == 4'b0110));
endmodule

bind ctl_unit ctl_unit_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stepNow  (stepNow),
  .funcCode (funcCode),
  .oeSel    (oeSel),
  .loadSel  (loadSel),
  .carryIn  (carryIn),
  .rotRight (rotRight),
  .rotEn    (rotEn)
);

// File: tb/sim_ctl_unit.sv
`timescale 1ns/1ps
module sim_ctl_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] funcCode = 4'd0;
  logic [2:0] oeSel, loadSel;
  logic       aluMode, carryIn, rotRight, rotEn;
  logic [1:0] aluFunc;

  int vecCount  = 0;
  int missCount = 0;
  logic [11:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  ctl_unit u0 (
    .clk(clk), .rst(rst), .funcCode(funcCode),
    .oeSel(oeSel), .loadSel(loadSel), .aluMode(aluMode), .aluFunc(aluFunc),
    .carryIn(carryIn), .rotRight(rotRight), .rotEn(rotEn)
  );

  function automatic logic [11:0] observed();
    return {oeSel, loadSel, aluMode, aluFunc, carryIn, rotRight, rotEn};
  endfunction

  // Reference table written from the requirements.
  function automatic logic [11:0] refStrobe(input logic [3:0] fc, input int step);
    logic [2:0] src, dst;
    logic m, ci, rr, re;
    logic [1:0] f;
    bit oneOp;
    src = 0; dst = 0; m = 0; f = 0; ci = 0; rr = 0; re = 0;
    if (fc[3]) return 12'd0;                              // R10
    oneOp = (fc == 4'd0) || (fc == 4'd6) || (fc == 4'd7);
    case (step)
      0: src = 3'd1;
      1: if (oneOp) src = 3'd1; else begin src = 3'd2; dst = 3'd1; end
      2: if (oneOp) begin src = 3'd2; dst = 3'd1; end else begin src = 3'd2; dst = 3'd2; end
      3: src = 3'd3;
      4: begin src = 3'd3; dst = 3'd3; end
      default: ;
    endcase
    if (step == 3 || step == 4) begin
      m  = (fc < 4'd4);
      f  = fc[1:0];
      ci = (fc == 4'd5);
      re = (fc == 4'd6) || (fc == 4'd7);
      rr = (fc == 4'd6);
    end
    return {src, dst, m, f, ci, rr, re};
  endfunction

  function automatic string reqFor(input logic [3:0] fc, input int step);
    if (fc[3]) return "R10";
    if (step >= 5) return "R6";
    if (step < 3) return ((fc == 0) || (fc == 6) || (fc == 7)) ? "R5" : "R4";
    if (fc == 5) return "R8";
    if (fc[2] && fc[1]) return "R9";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: called at a negedge where the step is 0; runs one full frame.
  task automatic runFrame(input logic [3:0] fc);
    funcCode = fc;
    for (int s = 0; s < 7; s++) begin
      expQ.push_back(refStrobe(fc, s));
      tagQ.push_back(reqFor(fc, s));
    end
    repeat (7) @(negedge clk);
  endtask

  // Monitor: samples between the negedge and the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) check(tagQ.pop_front(), observed(), expQ.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    rst = 1'b1;
    funcCode = 4'd4;
    @(negedge clk); #3;
    check("R2", observed(), 12'd0);          // quiet under reset
    @(negedge clk);
    rst = 1'b0;                              // step is 0 here
    // R3 R4 R5 R6 R7 R8 R9: every defined instruction, one frame each
    for (int c = 0; c < 8; c++) runFrame(4'(c));
    runFrame(4'd4);                          // R1: back-to-back frames wrap
    runFrame(4'd4);
    runFrame(4'b1000);                       // R10
    runFrame(4'b1111);                       // R10
    // R2: reset mid-frame
    funcCode = 4'd1;
    repeat (3) @(negedge clk);               // step 3
    rst = 1'b1;
    #3 check("R2", observed(), 12'd0);
    @(negedge clk);
    rst = 1'b0;
    #3 check("R2", observed(), refStrobe(4'd1, 0));
    @(negedge clk); #3;
    check("R1", observed(), refStrobe(4'd1, 1));
    @(negedge clk); #3;
    check("R1", observed(), refStrobe(4'd1, 2));
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule